// File: doc/BRIEF.md
# Thread Block Residency Admission Controller

This block guards the resident set of one streaming multiprocessor. A scheduler upstream offers one thread block at a time, tagged with its thread count. The controller grants the block only if two limits hold together: a cap on how many blocks may be resident and a cap on the total threads those blocks hold. Either limit may be the one that binds, depending on block size. With 64-thread blocks the block cap is reached first. With 256-thread blocks the thread cap is reached first.

A granted block is placed in the lowest-numbered free slot. The grant reports that slot and the number of 32-thread warps the block will form. The slot remembers the block's thread count, so a later retire event naming that slot returns exactly the capacity the block held. Blocks may retire in any order. A request that fits waits with ready low until enough capacity has been returned. A thread count that can never be legal is flagged for rejection at once.

Top module: `blk_admit_ctrl`

## Requirements
- R1: No more than MAX_BLOCKS (8) blocks are ever resident; while 8 are resident, `req_ready` is low.
- R2: The summed thread count of resident blocks never exceeds MAX_THREADS (768); a request whose count would push the sum past 768 sees `req_ready` low and waits.
- R3: A request whose `req_threads` is 0 or above MAX_BLOCK_THREADS (512) drives `req_reject` high combinationally while `req_valid` is high, and `req_ready` stays low for it.
- R4: While `req_ready` is high, `grant_warps` equals `req_threads` divided by 32, rounded up (a partial warp counts as a whole one).
- R5: While `req_ready` is high, `grant_slot` is the lowest-numbered slot not holding a resident block; a transfer happens on a clock edge where `req_valid` and `req_ready` are both high.
- R6: A retire (`ret_valid` high) naming an occupied slot frees that slot and subtracts that block's stored thread count; a retire naming a free slot changes nothing.
- R7: An accept and a retire in the same cycle are both applied: the block count is unchanged and the thread count moves by the difference.
- R8: `res_blocks` and `res_threads` show the resident totals and change one clock after the accept or retire edge.
- R9: After a clock edge with `rst_n` low, both counts are zero and all slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A block is offered |
| req_threads | input | 11 | Thread count of the offered block |
| req_ready | output | 1 | The offered count fits now; transfer when valid is also high |
| req_reject | output | 1 | The offered count is illegal and will never be granted |
| grant_slot | output | 3 | Slot the block will occupy |
| grant_warps | output | 5 | Warps the block will form |
| ret_valid | input | 1 | A resident block retires |
| ret_slot | input | 3 | Slot of the retiring block |
| res_blocks | output | 4 | Resident block count |
| res_threads | output | 10 | Resident thread count |

## Verification
The two functions that can share a cycle are admission and retirement: a grant into the lowest free slot while another slot is being released. The bench provokes this with a directed case in which a 256-thread block retires while a 128-thread block is granted. It also retires a random slot in about 40 percent of random cycles while requests keep arriving. A reference model applies both events to its own slot table. The bench then checks the next-cycle block and thread counts, and the slot that the following grant chooses.

// File: rtl/admit_pkg.sv
// Package admit_pkg
// Shared defaults and helpers for the residency admission controller.
// Assumes callers pass a positive warp size.
package admit_pkg;
    localparam int DEF_MAX_BLOCKS        = 8;
    localparam int DEF_MAX_THREADS       = 768;
    localparam int DEF_MAX_BLOCK_THREADS = 512;
    localparam int DEF_WARP_SIZE         = 32;

    // Number of warps needed for n threads, partial warp rounded up.
    function automatic int warps_for(input int n, input int ws);
        return (n + ws - 1) / ws;
    endfunction
endpackage

// File: rtl/admit_check.sv
// Module admit_check
// Combinational admission decision: legality of the requested size,
// fit against both residency caps, and the warp count of the block.
// Assumes the resident counts it is given never exceed their caps.
module admit_check #(
    parameter int MAX_BLOCKS        = admit_pkg::DEF_MAX_BLOCKS,
    parameter int MAX_THREADS       = admit_pkg::DEF_MAX_THREADS,
    parameter int MAX_BLOCK_THREADS = admit_pkg::DEF_MAX_BLOCK_THREADS,
    parameter int WARP_SIZE         = admit_pkg::DEF_WARP_SIZE,
    parameter int REQ_W             = 11,
    parameter int BLK_W             = 4,
    parameter int CNT_W             = 10,
    parameter int WARP_W            = 5
) (
    input  logic [REQ_W-1:0]  req_threads,
    input  logic [BLK_W-1:0]  cur_blocks,
    input  logic [CNT_W-1:0]  cur_threads,
    input  logic              slot_avail,
    output logic              size_legal,
    output logic              fits,
    output logic [WARP_W-1:0] warps
);
    // Size legality, dual-cap fit test and warp rounding.
    always_comb begin
        int n;
        n          = int'(req_threads);
        size_legal = (n >= 1) && (n <= MAX_BLOCK_THREADS);
        fits       = size_legal && slot_avail
                     && (int'(cur_blocks) + 1 <= MAX_BLOCKS)
                     && (int'(cur_threads) + n <= MAX_THREADS);
        warps      = WARP_W'(admit_pkg::warps_for(n, WARP_SIZE));
    end
endmodule

// File: rtl/slot_table.sv
// Module slot_table
// Holds the occupancy flag and the stored thread count of each block slot,
// finds the lowest free slot, and validates retire requests.
// Assumes alloc_en is raised only when free_any is high.
module slot_table #(
    parameter int NSLOT  = admit_pkg::DEF_MAX_BLOCKS,
    parameter int SLOT_W = 3,
    parameter int TW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TW-1:0]     alloc_threads,
    input  logic              ret_en,
    input  logic [SLOT_W-1:0] ret_slot,
    output logic [NSLOT-1:0]  occ,
    output logic [SLOT_W-1:0] free_slot,
    output logic              free_any,
    output logic              ret_ok,
    output logic [TW-1:0]     ret_threads
);
    logic [TW-1:0] thr_mem [NSLOT];

    // Lowest-numbered free slot search (scan downward so the lowest wins).
    always_comb begin
        free_slot = '0;
        free_any  = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_slot = SLOT_W'(i);
                free_any  = 1'b1;
            end
        end
    end

    // A retire counts only when it names an existing, occupied slot.
    always_comb begin
        ret_ok      = ret_en && (int'(ret_slot) < NSLOT) && occ[ret_slot];
        ret_threads = ret_ok ? thr_mem[ret_slot] : '0;
    end

    // Occupancy flag and stored size per slot.
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    occ[s]     <= 1'b0;
                    thr_mem[s] <= '0;
                end else if (alloc_en && int'(free_slot) == s) begin
                    occ[s]     <= 1'b1;
                    thr_mem[s] <= alloc_threads;
                end else if (ret_ok && int'(ret_slot) == s) begin
                    occ[s]     <= 1'b0;
                end
            end
        end
    endgenerate

    // R6: a validated retire leaves its slot free on the next cycle.
    a_r6_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ok && !(alloc_en && free_slot == ret_slot)) |=> !occ[$past(ret_slot)]);
    // R5: an allocation fills a slot that was free.
    a_r5_alloc_target_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> occ[$past(free_slot)]);
endmodule

// File: rtl/res_counter.sv
// Module res_counter
// Resident block and thread totals, updated from accept and retire events
// that may both occur in the same cycle.
// Assumes the caller never accepts past either cap.
module res_counter #(
    parameter int MAX_BLOCKS  = admit_pkg::DEF_MAX_BLOCKS,
    parameter int MAX_THREADS = admit_pkg::DEF_MAX_THREADS,
    parameter int BLK_W       = 4,
    parameter int CNT_W       = 10,
    parameter int TW          = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [TW-1:0]    acc_threads,
    input  logic             ret_en,
    input  logic [TW-1:0]    ret_threads,
    output logic [BLK_W-1:0] blocks,
    output logic [CNT_W-1:0] threads
);
    // Net update of both totals from the accept and retire of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocks  <= '0;
            threads <= '0;
        end else begin
            blocks  <= blocks + BLK_W'(acc_en) - BLK_W'(ret_en);
            threads <= threads + (acc_en ? CNT_W'(acc_threads) : '0)
                               - (ret_en ? CNT_W'(ret_threads) : '0);
        end
    end

    // R1: block cap never exceeded.
    a_r1_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blocks) <= MAX_BLOCKS);
    // R2: thread cap never exceeded.
    a_r2_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(threads) <= MAX_THREADS);
endmodule

// File: rtl/blk_admit_ctrl.sv
// Module blk_admit_ctrl
// Admits thread blocks onto one multiprocessor under a block-count cap and
// a thread-count cap, assigns the lowest free slot, reports the warp count,
// and takes retire events per slot. The grant decision uses the counts held
// at the start of the cycle; a same-cycle retire is credited from the next.
// Assumes a requester drops a request that is flagged for rejection.
module blk_admit_ctrl #(
    parameter int MAX_BLOCKS        = admit_pkg::DEF_MAX_BLOCKS,
    parameter int MAX_THREADS       = admit_pkg::DEF_MAX_THREADS,
    parameter int MAX_BLOCK_THREADS = admit_pkg::DEF_MAX_BLOCK_THREADS,
    parameter int WARP_SIZE         = admit_pkg::DEF_WARP_SIZE,
    parameter int REQ_W             = 11,
    localparam int SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
    localparam int BLK_W  = $clog2(MAX_BLOCKS + 1),
    localparam int CNT_W  = $clog2(MAX_THREADS + 1),
    localparam int TW     = $clog2(MAX_BLOCK_THREADS + 1),
    localparam int WARP_W = $clog2(MAX_BLOCK_THREADS / WARP_SIZE + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [REQ_W-1:0]  req_threads,
    output logic              req_ready,
    output logic              req_reject,
    output logic [SLOT_W-1:0] grant_slot,
    output logic [WARP_W-1:0] grant_warps,
    input  logic              ret_valid,
    input  logic [SLOT_W-1:0] ret_slot,
    output logic [BLK_W-1:0]  res_blocks,
    output logic [CNT_W-1:0]  res_threads
);
    logic                  size_legal, fits, free_any, accept, ret_ok;
    logic [MAX_BLOCKS-1:0] occ;
    logic [TW-1:0]         ret_threads;

    // Handshake and reject flags from the admission decision.
    always_comb begin
        req_ready  = fits;
        req_reject = req_valid && !size_legal;
        accept     = req_valid && fits;
    end

    admit_check #(
        .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
        .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .WARP_SIZE(WARP_SIZE),
        .REQ_W(REQ_W), .BLK_W(BLK_W), .CNT_W(CNT_W), .WARP_W(WARP_W)
    ) check_i (
        .req_threads(req_threads), .cur_blocks(res_blocks),
        .cur_threads(res_threads), .slot_avail(free_any),
        .size_legal(size_legal), .fits(fits), .warps(grant_warps)
    );

    slot_table #(.NSLOT(MAX_BLOCKS), .SLOT_W(SLOT_W), .TW(TW)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(accept), .alloc_threads(TW'(req_threads)),
        .ret_en(ret_valid), .ret_slot(ret_slot),
        .occ(occ), .free_slot(grant_slot), .free_any(free_any),
        .ret_ok(ret_ok), .ret_threads(ret_threads)
    );

    res_counter #(
        .MAX_BLOCKS(MAX_BLOCKS), .MAX_THREADS(MAX_THREADS),
        .BLK_W(BLK_W), .CNT_W(CNT_W), .TW(TW)
    ) count_i (
        .clk(clk), .rst_n(rst_n),
        .acc_en(accept), .acc_threads(TW'(req_threads)),
        .ret_en(ret_ok), .ret_threads(ret_threads),
        .blocks(res_blocks), .threads(res_threads)
    );

    // R3: an illegal size is never granted.
    a_r3_illegal_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !req_ready);
    // R8: the block counter agrees with the slot table.
    a_r8_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == int'(res_blocks));
    // R7: accept plus retire in one cycle keeps the block count.
    a_r7_swap_keeps_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ret_ok) |=> res_blocks == $past(res_blocks));
    // R9: reset clears both totals.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (res_blocks == '0 && res_threads == '0));
endmodule

// File: tb/blk_admit_ctrl_tb.sv
`timescale 1ns/1ps
module blk_admit_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_threads = '0;
    logic        req_ready, req_reject;
    logic [2:0]  grant_slot;
    logic [4:0]  grant_warps;
    logic        ret_valid = 1'b0;
    logic [2:0]  ret_slot = '0;
    logic [3:0]  res_blocks;
    logic [9:0]  res_threads;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit m_occ [8];
    int m_thr [8];

    always #2.5 clk = ~clk;

    blk_admit_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
        .req_ready(req_ready), .req_reject(req_reject), .grant_slot(grant_slot),
        .grant_warps(grant_warps), .ret_valid(ret_valid), .ret_slot(ret_slot),
        .res_blocks(res_blocks), .res_threads(res_threads)
    );

    function automatic int m_blocks();
        int c = 0;
        for (int i = 0; i < 8; i++) c += m_occ[i] ? 1 : 0;
        return c;
    endfunction

    function automatic int m_threads();
        int c = 0;
        for (int i = 0; i < 8; i++) c += m_occ[i] ? m_thr[i] : 0;
        return c;
    endfunction

    function automatic int m_low_free();
        for (int i = 0; i < 8; i++) if (!m_occ[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: check totals, drive, check combinational grant, update model.
    task automatic step(input bit v, input int thr, input bit rv, input int rs);
        bit legal, fit;
        int slot;
        @(negedge clk);
        chk("R8 res_blocks", int'(res_blocks), m_blocks());
        chk("R8 res_threads", int'(res_threads), m_threads());
        req_valid   = v;
        req_threads = 11'(thr);
        ret_valid   = rv;
        ret_slot    = 3'(rs);
        #1;
        legal = (thr >= 1) && (thr <= 512);
        slot  = m_low_free();
        fit   = legal && (m_blocks() + 1 <= 8) && (m_threads() + thr <= 768);
        chk("R1/R2 req_ready", int'(req_ready), int'(fit));
        chk("R3 req_reject", int'(req_reject), int'(v && !legal));
        if (fit) begin
            chk("R5 grant_slot", int'(grant_slot), slot);
            chk("R4 grant_warps", int'(grant_warps), (thr + 31) / 32);
        end
        if (rv && m_occ[rs]) m_occ[rs] = 0;   // R6: free slot retire ignored
        if (v && fit) begin
            m_occ[slot] = 1;
            m_thr[slot] = thr;
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_occ[i] = 0; m_thr[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 blocks after reset", int'(res_blocks), 0);
        chk("R9 threads after reset", int'(res_threads), 0);
        // R1: 64-thread blocks, block cap binds at 8 / 512 threads
        for (int i = 0; i < 9; i++) step(1, 64, 0, 0);
        idle();
        chk("R1 blocks at block cap", int'(res_blocks), 8);
        chk("R1 threads at block cap", int'(res_threads), 512);
        // R6: retire in non-sequential order
        for (int i = 7; i >= 0; i--) step(0, 0, 1, (i * 3) % 8);
        idle();
        chk("R6 all retired", int'(res_blocks), 0);
        // R6: retire of a free slot is ignored
        step(0, 0, 1, 5);
        idle();
        chk("R6 free-slot retire ignored", int'(res_threads), 0);
        // R2: 256-thread blocks, thread cap binds at 3
        for (int i = 0; i < 4; i++) step(1, 256, 0, 0);
        idle();
        chk("R2 threads at thread cap", int'(res_threads), 768);
        chk("R2 blocks at thread cap", int'(res_blocks), 3);
        // R7: retire slot 1 while a 128 block is offered (sees full count, waits)
        step(1, 128, 1, 1);
        // R7: now slot 1 free; retire slot 0 and accept 128 into slot 1
        step(1, 128, 1, 0);
        idle();
        chk("R7 swap blocks", int'(res_blocks), 2);
        chk("R7 swap threads", int'(res_threads), 384);
        // R3: illegal sizes
        step(1, 1024, 0, 0);
        step(1, 0, 0, 0);
        step(1, 513, 0, 0);
        // R4: partial warps
        step(1, 33, 0, 0);
        step(1, 1, 0, 0);
        idle();
        // clear
        for (int i = 0; i < 8; i++) step(0, 0, 1, i);
        // Random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            int pick;
            int sizes [10] = '{1, 31, 32, 64, 100, 128, 256, 512, 0, 700};
            pick = int'($urandom % 10);
            step(($urandom % 4) != 0, sizes[pick], ($urandom % 5) < 2, int'($urandom % 8));
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule